// File: doc/BRIEF.md
# Four-Error ECC Correction Sequencer

This block drives the control flow around a four-error syndrome decoder that protects 512-byte sectors. A run starts with a pulse on `start_i`. At that pulse the block latches the ten stored ECC bytes for the sector. It splits them into eight 10-bit codes and writes the codes into the decoder. It then reads back the syndrome and, if the syndrome is not zero, starts error location and polls the decoder until the decoder reports a result.

For every error the decoder finds, the block reads an address and a value. It turns the address into a byte offset within the sector. When the offset falls inside the data area, it presents an XOR-correction request to the sector buffer.

The decoder is reached through a register-style port with one outstanding transaction at a time. A transaction is a request held until it is acknowledged, and read data comes back with the acknowledge. The decoder can briefly report "addresses ready" straight after location is started, before it has done any work. The sequencer therefore first waits, with a cycle-count timeout, until the decoder shows it is busy. Only after that does it decode the state.

Top module: `ecc4_fix_seq`

## Requirements
- R1: While `rst_ni` is low, `done_o`, `reg_req_o`, `fix_valid_o`, `uncorr_o` and `fixed_cnt_o` are all zero.
- R2: ECC byte j is taken from `ecc_bytes_i[8j+7:8j]` when `start_i` is accepted. Code k is bits `[10k+9:10k]` of that 80-bit value. The eight codes are written to select 0 (load) in the order code 7 first and code 0 last. Each write carries the code in `reg_wdata_o[9:0]` with zeros above it.
- R3: Four syndrome words are read on selects 1, 2, 3 and 4, and only the bits under mask 0x03FF03FF are looked at. If all masked bits are zero, the run ends with a count of 0 and makes no further requests, so a run has 12 requests in total.
- R4: For a non-zero syndrome, one read of select 5 (first address word) comes before the location-start write on select 10.
- R5: After the start write, the status word (select 9) is read until its state field, bits [11:8], is 4 or more, or until `TMO_CYC` cycles have passed. Only then is the state decoded, and a timeout does not abort the run.
- R6: The decoded state means the following: 0 ends the run with a count of 0, and 1 ends it with `uncorr_o` set. A state of 2 or 3 means there are 1 + bits [17:16] errors to read back. A state of 4 or above causes another status read.
- R7: In the state-0 and state-1 cases, one read of select 7 (first value word) is made before `done_o`.
- R8: Errors 0 and 1 use selects 5 and 7, and errors 2 and 3 use selects 6 and 8. Odd-numbered errors come from bits [31:16] and even-numbered errors from bits [15:0]. The address is the low 10 bits of its half and the XOR mask is the low 8 bits of its half.
- R9: The correction offset is 519 minus the address. A correction is issued only when the address is between 8 and 519 inclusive, and `fixed_cnt_o` counts only the corrections issued.
- R10: Once `fix_valid_o` is raised, it stays high with `fix_off_o` and `fix_mask_o` unchanged until `fix_ready_i` is high.
- R11: A `start_i` pulse that arrives while a run is in progress is ignored.
- R12: `done_o` is a single-cycle pulse. `fixed_cnt_o` and `uncorr_o` keep their values from that pulse until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a correction run when idle |
| ecc_bytes_i | input | 80 | Ten stored ECC bytes, byte 0 in the low bits |
| reg_req_o | output | 1 | Decoder transaction request |
| reg_we_o | output | 1 | Transaction is a write |
| reg_sel_o | output | 4 | Decoder register select |
| reg_wdata_o | output | 32 | Write data |
| reg_ack_i | input | 1 | Transaction complete; read data valid |
| reg_rdata_i | input | 32 | Read data |
| fix_valid_o | output | 1 | Correction request valid |
| fix_ready_i | input | 1 | Sector buffer accepts correction |
| fix_off_o | output | 9 | Byte offset in sector |
| fix_mask_o | output | 8 | XOR mask for that byte |
| done_o | output | 1 | Run finished (one cycle) |
| uncorr_o | output | 1 | Five or more errors reported |
| fixed_cnt_o | output | 3 | Number of corrections issued |

## Verification
A new start request can land in the same cycle as a step of a run that is already in progress. The bench provokes this by pulsing `start_i` about twenty cycles into a run, while code loading and syndrome reads are under way. It then judges the outcome at the ports: the decoder model must count exactly eight load writes, and the run must end with the same corrections as an undisturbed run.

A correction request and the next decoder access also compete for the same cycles. The bench drives `fix_ready_i` low on a repeating pattern, and its decoder model withholds error addresses until the final status has been read. A run that decodes the early "ready" state or advances past a stalled correction therefore shows wrong offsets or a wrong count.

// File: rtl/ecc4_pkg.sv
package ecc4_pkg;
  localparam int unsigned NCODE     = 8;
  localparam int unsigned CODE_W    = 10;
  localparam int unsigned NBYTE     = 10;
  localparam int unsigned SEC_BYTES = 512;
  localparam int unsigned ADDR_BIAS = 519;
  localparam int unsigned ST_LSB    = 8;
  localparam int unsigned CNT_LSB   = 16;
  localparam logic [31:0] SYN_MASK  = 32'h03ff_03ff;

  typedef enum logic [3:0] {
    SEL_LOAD    = 4'd0,
    SEL_SYN0    = 4'd1,
    SEL_SYN1    = 4'd2,
    SEL_SYN2    = 4'd3,
    SEL_SYN3    = 4'd4,
    SEL_ADDR_LO = 4'd5,
    SEL_ADDR_HI = 4'd6,
    SEL_VAL_LO  = 4'd7,
    SEL_VAL_HI  = 4'd8,
    SEL_STAT    = 4'd9,
    SEL_GO      = 4'd10
  } reg_sel_e;

  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_SYN, S_CLR, S_GO, S_WAIT, S_POLL,
    S_DUMMY, S_ADDR, S_VAL, S_FIX, S_DONE
  } seq_st_e;
endpackage

// File: rtl/ecc4_code_unpack.sv
module ecc4_code_unpack #(
  parameter int unsigned NCODE  = 8,
  parameter int unsigned CODE_W = 10,
  localparam int unsigned IDX_W = $clog2(NCODE)
) (
  input  logic [NCODE*CODE_W-1:0] packed_i,
  input  logic [IDX_W-1:0]        idx_i,
  output logic [CODE_W-1:0]       code_o
);
  logic [CODE_W-1:0] codes [NCODE];

  for (genvar k = 0; k < NCODE; k++) begin : g_code
    assign codes[k] = packed_i[k*CODE_W +: CODE_W];
  end

  assign code_o = codes[idx_i];
endmodule

// File: rtl/ecc4_err_map.sv
module ecc4_err_map #(
  parameter int unsigned AW   = 10,
  parameter int unsigned SEC  = 512,
  parameter int unsigned BIAS = 519,
  localparam int unsigned OFF_W = $clog2(SEC)
) (
  input  logic [AW-1:0]    raw_i,
  output logic [OFF_W-1:0] off_o,
  output logic             hit_o
);
  logic [AW:0] diff;

  // reversed mapping; wrap of raw > BIAS lands far above SEC
  assign diff  = (AW+1)'(BIAS) - {1'b0, raw_i};
  assign hit_o = ({1'b0, raw_i} <= (AW+1)'(BIAS)) && (diff < (AW+1)'(SEC));
  assign off_o = diff[OFF_W-1:0];

  logic diff_unused;
  assign diff_unused = ^diff[AW:OFF_W];
endmodule

// File: rtl/ecc4_wait_timer.sv
module ecc4_wait_timer #(
  parameter int unsigned LIMIT = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (run_i && !expired_o) cnt_q <= cnt_q + W'(1);
  end

  assign expired_o = (cnt_q == W'(LIMIT));

  // R5
  tmo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o && !clr_i |=> expired_o);
endmodule

// File: rtl/ecc4_fix_seq.sv
module ecc4_fix_seq
  import ecc4_pkg::*;
#(
  parameter int unsigned TMO_CYC = 5000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [79:0] ecc_bytes_i,
  output logic        reg_req_o,
  output logic        reg_we_o,
  output logic [3:0]  reg_sel_o,
  output logic [31:0] reg_wdata_o,
  input  logic        reg_ack_i,
  input  logic [31:0] reg_rdata_i,
  output logic        fix_valid_o,
  input  logic        fix_ready_i,
  output logic [8:0]  fix_off_o,
  output logic [7:0]  fix_mask_o,
  output logic        done_o,
  output logic        uncorr_o,
  output logic [2:0]  fixed_cnt_o
);
  localparam int unsigned ECC_W = NBYTE * 8;

  seq_st_e          state_q;
  logic [ECC_W-1:0] ecc_q;
  logic [2:0]       ld_idx_q;
  logic [1:0]       syn_idx_q, err_idx_q, err_last_q;
  logic             syn_or_q, uncorr_q;
  logic [9:0]       raw_q;
  logic [7:0]       mask_q;
  logic [2:0]       fixed_q;
  logic [9:0]       code;
  logic             tmo_exp, hit;
  logic [15:0]      half;
  logic [3:0]       st_f;
  logic [1:0]       cnt_f;
  logic             syn_hit;
  reg_sel_e         sel;

  ecc4_code_unpack #(.NCODE(NCODE), .CODE_W(CODE_W)) u_unpack (
    .packed_i(ecc_q), .idx_i(ld_idx_q), .code_o(code));

  ecc4_err_map #(.AW(10), .SEC(SEC_BYTES), .BIAS(ADDR_BIAS)) u_map (
    .raw_i(raw_q), .off_o(fix_off_o), .hit_o(hit));

  ecc4_wait_timer #(.LIMIT(TMO_CYC)) u_tmo (
    .clk_i, .rst_ni, .clr_i(state_q == S_GO),
    .run_i(state_q == S_WAIT), .expired_o(tmo_exp));

  assign half    = err_idx_q[0] ? reg_rdata_i[31:16] : reg_rdata_i[15:0];
  assign st_f    = reg_rdata_i[ST_LSB +: 4];
  assign cnt_f   = reg_rdata_i[CNT_LSB +: 2];
  assign syn_hit = |(reg_rdata_i & SYN_MASK);

  logic rdata_unused;
  assign rdata_unused = ^{reg_rdata_i[31:18], reg_rdata_i[15:12], reg_rdata_i[7:0], half[15:10]};

  always_comb begin
    reg_req_o   = 1'b1;
    reg_we_o    = 1'b0;
    reg_wdata_o = '0;
    sel         = SEL_STAT;
    unique case (state_q)
      S_LOAD:  begin sel = SEL_LOAD; reg_we_o = 1'b1; reg_wdata_o = 32'(code); end
      S_SYN:   sel = reg_sel_e'(SEL_SYN0 + {2'b00, syn_idx_q});
      S_CLR:   sel = SEL_ADDR_LO;
      S_GO:    begin sel = SEL_GO; reg_we_o = 1'b1; end
      S_WAIT, S_POLL: sel = SEL_STAT;
      S_DUMMY: sel = SEL_VAL_LO;
      S_ADDR:  sel = err_idx_q[1] ? SEL_ADDR_HI : SEL_ADDR_LO;
      S_VAL:   sel = err_idx_q[1] ? SEL_VAL_HI : SEL_VAL_LO;
      default: reg_req_o = 1'b0;
    endcase
  end

  assign reg_sel_o   = sel;
  assign fix_valid_o = (state_q == S_FIX);
  assign fix_mask_o  = mask_q;
  assign done_o      = (state_q == S_DONE);
  assign uncorr_o    = uncorr_q;
  assign fixed_cnt_o = fixed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      ecc_q      <= '0;
      ld_idx_q   <= '0;
      syn_idx_q  <= '0;
      syn_or_q   <= 1'b0;
      err_idx_q  <= '0;
      err_last_q <= '0;
      raw_q      <= '0;
      mask_q     <= '0;
      fixed_q    <= '0;
      uncorr_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          ecc_q    <= ecc_bytes_i;
          ld_idx_q <= 3'(NCODE - 1);
          fixed_q  <= '0;
          uncorr_q <= 1'b0;
          state_q  <= S_LOAD;
        end
        S_LOAD: if (reg_ack_i) begin
          if (ld_idx_q == '0) begin
            syn_idx_q <= '0;
            syn_or_q  <= 1'b0;
            state_q   <= S_SYN;
          end else ld_idx_q <= ld_idx_q - 3'd1;
        end
        S_SYN: if (reg_ack_i) begin
          syn_or_q  <= syn_or_q | syn_hit;
          syn_idx_q <= syn_idx_q + 2'd1;
          if (syn_idx_q == 2'd3) state_q <= (syn_or_q || syn_hit) ? S_CLR : S_DONE;
        end
        S_CLR: if (reg_ack_i) state_q <= S_GO;
        S_GO:  if (reg_ack_i) state_q <= S_WAIT;
        // early "ready" reads are discarded until busy is seen or time runs out
        S_WAIT: if (reg_ack_i && (st_f >= 4'd4 || tmo_exp)) state_q <= S_POLL;
        S_POLL: if (reg_ack_i) begin
          unique case (st_f)
            4'd0: state_q <= S_DUMMY;
            4'd1: begin uncorr_q <= 1'b1; state_q <= S_DUMMY; end
            4'd2, 4'd3: begin
              err_last_q <= cnt_f;
              err_idx_q  <= '0;
              state_q    <= S_ADDR;
            end
            default: state_q <= S_POLL;
          endcase
        end
        S_DUMMY: if (reg_ack_i) state_q <= S_DONE;
        S_ADDR: if (reg_ack_i) begin
          raw_q   <= half[9:0];
          state_q <= S_VAL;
        end
        S_VAL: if (reg_ack_i) begin
          mask_q <= half[7:0];
          if (hit)                          state_q <= S_FIX;
          else if (err_idx_q == err_last_q) state_q <= S_DONE;
          else begin err_idx_q <= err_idx_q + 2'd1; state_q <= S_ADDR; end
        end
        S_FIX: if (fix_ready_i) begin
          fixed_q <= fixed_q + 3'd1;
          if (err_idx_q == err_last_q) state_q <= S_DONE;
          else begin err_idx_q <= err_idx_q + 2'd1; state_q <= S_ADDR; end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R10
  fix_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_valid_o && !fix_ready_i |=> fix_valid_o && $stable(fix_off_o) && $stable(fix_mask_o));
  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && !reg_ack_i |=> reg_req_o && $stable(reg_sel_o) && $stable(reg_we_o) && $stable(reg_wdata_o));
  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  fix_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> fixed_cnt_o <= 3'd4);
  // R12
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o && !start_i && !fix_valid_o |=> $stable(fixed_cnt_o));
endmodule

// File: tb/sim_ecc4_fix_seq.sv
module sim_ecc4_fix_seq;
  localparam int TMO = 5000;

  typedef struct packed {
    logic [79:0] ecc;
    logic        syn;
    logic [3:0]  n3;
    logic [3:0]  nb;
    logic [3:0]  st;
    logic [1:0]  cnt;
    logic [39:0] a;
    logic [31:0] v;
  } vec_t;

  localparam vec_t TBL [7] = '{
    '{80'h0123_4567_89ab_cdef_0f1e, 1'b0, 4'd0, 4'd1, 4'd2, 2'd0, 40'd0, 32'd0},
    '{80'hffee_ddcc_bbaa_9988_7766, 1'b1, 4'd1, 4'd1, 4'd2, 2'd0,
      {10'd0, 10'd0, 10'd0, 10'd519}, 32'h0000_0001},
    '{80'h5a5a_0f0f_3c3c_c3c3_a5a5, 1'b1, 4'd2, 4'd2, 4'd3, 2'd3,
      {10'd600, 10'd7, 10'd300, 10'd8}, {8'h22, 8'h11, 8'h5a, 8'h80}},
    '{80'h1111_2222_3333_4444_5555, 1'b1, 4'd1, 4'd2, 4'd1, 2'd2,
      {10'd9, 10'd9, 10'd9, 10'd9}, 32'hffff_ffff},
    '{80'h8000_0000_0000_0000_0001, 1'b1, 4'd0, 4'd1, 4'd0, 2'd1,
      {10'd9, 10'd9, 10'd9, 10'd9}, 32'hffff_ffff},
    '{80'h0fed_cba9_8765_4321_0abc, 1'b1, 4'd0, 4'd3, 4'd2, 2'd2,
      {10'd0, 10'd12, 10'd520, 10'd100}, {8'h00, 8'hc3, 8'h77, 8'h3c}},
    '{80'h3ff0_0ffc_03ff_c00f_f003, 1'b1, 4'd3, 4'd1, 4'd3, 2'd3,
      {10'd40, 10'd30, 10'd20, 10'd10}, {8'h04, 8'h03, 8'h02, 8'h01}}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, fix_ready = 1'b1;
  logic [79:0] ecc_in = '0;
  logic req, we, ack, fix_valid, done, uncorr;
  logic [3:0] sel;
  logic [31:0] wdata, rdata;
  logic [8:0] fix_off;
  logic [7:0] fix_mask;
  logic [2:0] fixed_cnt;

  always #10 clk = ~clk;

  ecc4_fix_seq #(.TMO_CYC(TMO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ecc_bytes_i(ecc_in),
    .reg_req_o(req), .reg_we_o(we), .reg_sel_o(sel), .reg_wdata_o(wdata),
    .reg_ack_i(ack), .reg_rdata_i(rdata),
    .fix_valid_o(fix_valid), .fix_ready_i(fix_ready), .fix_off_o(fix_off),
    .fix_mask_o(fix_mask), .done_o(done), .uncorr_o(uncorr), .fixed_cnt_o(fixed_cnt));

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  // decoder model configuration
  bit c_syn; int c_n3, c_nb, c_gate; logic [3:0] c_st; logic [1:0] c_cnt;
  logic [39:0] c_a; logic [31:0] c_v;
  bit stall = 1'b0;
  // model observations
  int n_req, n_load, n_val1_after_go, stat_j, go_cyc, addr_cyc, n_fix;
  bit go_seen, clr_seen, clr_ok;
  logic [31:0] load_log [8];
  logic [8:0] fix_off_log [4];
  logic [7:0] fix_mask_log [4];

  function automatic logic [15:0] half_of(input int i, input bit is_val);
    return is_val ? {8'hee, c_v[8*i +: 8]} : {6'b101010, c_a[10*i +: 10]};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fix_valid && fix_ready && n_fix < 4) begin
      fix_off_log[n_fix] = fix_off;
      fix_mask_log[n_fix] = fix_mask;
      n_fix++;
    end else if (fix_valid && fix_ready) n_fix++;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0; rdata <= '0;
    end else begin
      ack <= req && !ack;
      if (req && !ack) begin
        n_req++;
        rdata <= '0;
        case (sel)
          4'd0: begin if (n_load < 8) load_log[n_load] = wdata; n_load++; end
          4'd1, 4'd2, 4'd4: rdata <= 32'hfc00_fc00;
          4'd3: rdata <= c_syn ? 32'h0001_0000 : 32'hfc00_fc00;
          4'd5, 4'd6, 4'd7, 4'd8: begin
            if (!go_seen && sel == 4'd5) clr_seen = 1'b1;
            if (go_seen && sel == 4'd7) n_val1_after_go++;
            if ((sel == 4'd5 || sel == 4'd6) && go_seen && addr_cyc < 0) addr_cyc = cyc;
            if (go_seen && stat_j >= c_gate) begin
              if (sel == 4'd5) rdata <= {half_of(1, 0), half_of(0, 0)};
              if (sel == 4'd6) rdata <= {half_of(3, 0), half_of(2, 0)};
              if (sel == 4'd7) rdata <= {half_of(1, 1), half_of(0, 1)};
              if (sel == 4'd8) rdata <= {half_of(3, 1), half_of(2, 1)};
            end
          end
          4'd9: begin
            logic [3:0] s;
            s = (stat_j < c_n3) ? 4'd3 : (stat_j < c_n3 + c_nb) ? 4'hc : c_st;
            rdata <= {14'd0, c_cnt, 4'd0, s, 8'ha5};
            stat_j++;
          end
          4'd10: begin go_seen = 1'b1; clr_ok = clr_seen; stat_j = 0; go_cyc = cyc; end
          default: ;
        endcase
      end
    end
  end

  initial forever begin
    @(negedge clk);
    fix_ready = stall ? (cyc % 3 == 0) : 1'b1;
  end

  task automatic chk(input string r, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic clear_model();
    n_req = 0; n_load = 0; n_val1_after_go = 0; stat_j = 0; n_fix = 0;
    go_seen = 0; clr_seen = 0; clr_ok = 0; go_cyc = 0; addr_cyc = -1;
  endtask

  task automatic run_and_check(input bit stuck, input bit restart);
    int t;
    int e_nfix, e_nreq;
    bit e_unc;
    logic [3:0] e_st;
    logic [8:0] e_off [4];
    logic [7:0] e_msk [4];
    clear_model();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (restart) begin
      repeat (20) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk("R12", "done seen", done, 1);
    // expected values from the requirements
    e_st = stuck ? 4'd3 : c_st;
    e_unc = c_syn && e_st == 4'd1;
    e_nfix = 0;
    if (c_syn && (e_st == 4'd2 || e_st == 4'd3))
      for (int i = 0; i <= int'(c_cnt); i++) begin
        int a;
        a = int'(c_a[10*i +: 10]);
        if (a >= 8 && a <= 519) begin
          e_off[e_nfix] = 9'(519 - a);
          e_msk[e_nfix] = c_v[8*i +: 8];
          e_nfix++;
        end
      end
    chk("R9", "fixed count", fixed_cnt, e_nfix);
    chk("R6", "uncorrectable flag", uncorr, e_unc);
    chk("R9", "issued corrections", n_fix, e_nfix);
    for (int i = 0; i < e_nfix && i < n_fix; i++) begin
      chk("R8", "fix offset", fix_off_log[i], e_off[i]);
      chk("R8", "fix mask", fix_mask_log[i], e_msk[i]);
    end
    for (int j = 0; j < 8; j++)
      chk("R2", "load order", load_log[j], {22'd0, ecc_in[10*(7-j) +: 10]});
    if (!c_syn) begin
      repeat (4) @(negedge clk);
      chk("R3", "requests on zero syndrome", n_req, 12);
    end else begin
      chk("R4", "clear read before start", clr_ok, 1);
      if (e_st <= 4'd1) chk("R7", "dummy value read", n_val1_after_go, 1);
      if (stuck) chk("R5", "timeout wait elapsed", (addr_cyc - go_cyc) >= TMO, 1);
    end
    e_nreq = n_req;
    repeat (3) @(negedge clk);
    chk("R12", "done low after pulse", done, 0);
    chk("R12", "count held", fixed_cnt, e_nfix);
    chk("R11", "no extra run", n_load, 8);
    chk("R11", "no extra requests", n_req, e_nreq);
  endtask

  task automatic load_vec(input vec_t v);
    ecc_in = v.ecc; c_syn = v.syn; c_n3 = int'(v.n3); c_nb = int'(v.nb);
    c_st = v.st; c_cnt = v.cnt; c_a = v.a; c_v = v.v;
    c_gate = c_n3 + c_nb + 1;
  endtask

  initial begin
    clear_model();
    load_vec(TBL[0]);
    repeat (3) @(negedge clk);
    // R1
    chk("R1", "done in reset", done, 0);
    chk("R1", "req in reset", req, 0);
    chk("R1", "fix_valid in reset", fix_valid, 0);
    chk("R1", "uncorr in reset", uncorr, 0);
    chk("R1", "count in reset", fixed_cnt, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 7; i++) begin
      load_vec(TBL[i]);
      stall = (i % 2 == 0);
      run_and_check(1'b0, 1'b0);
    end

    // R11: start pulse during a run
    load_vec(TBL[2]);
    stall = 1'b1;
    run_and_check(1'b0, 1'b1);

    // R5: decoder never leaves the early state, timeout then proceeds
    load_vec(TBL[6]);
    c_n3 = 1000000; c_nb = 0; c_gate = 0; c_cnt = 2'd1;
    stall = 1'b0;
    run_and_check(1'b1, 1'b0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule